// File: doc/BRIEF.md
# Lane-Count Masked SIMD Integer Execute Stage

This block is the execute stage of an integer SIMD datapath. It holds eight 16-bit lanes, so a vector is 128 bits wide. Lane i occupies bits [16i+15:16i]. Each instruction arrives with an opcode, two source vectors, the present contents of the destination register and a lane count. Only the lanes below that count take part.

The stage turns the count into a thermometer enable mask. Active lanes compute add, subtract, unsigned minimum, unsigned maximum or unsigned divide. Inactive lanes pass the old destination element through unchanged, raise no divide-by-zero flag and assert no store write enable. There is no separate length register: the count comes with every instruction, so consecutive instructions can use different widths with no setup step and no bubble.

The outputs are the merged destination vector, per-element and per-byte write enables for a store path, a per-lane divide-by-zero vector and a single exception bit. All of them are registered one cycle after the input strobe.

Top module: `simd_lane_exec`

## Requirements
- R1: While rst_ni is low, valid_o, dst_o, elem_we_o, byte_we_o, dz_lane_o and exc_o are all zero.
- R2: A strobe on valid_i produces valid_o exactly one cycle later. Instructions may issue on consecutive cycles, each with a different lane count, with no idle cycle between them.
- R3: For a lane count n from 1 to 8, lanes 0 to n-1 are active. Counts from 9 to 15 act as 8. A count of 0 activates no lane, so the output equals the old destination with no write enable and no exception.
- R4: In an active lane the opcodes give these results. 0 gives a+b and 1 gives a-b, both modulo 2^16. 2 gives the unsigned minimum and 3 the unsigned maximum. 4 gives the unsigned quotient a/b, or 0xFFFF when b is zero.
- R5: Opcodes 5 to 7 return the old destination element in every lane. The write enables still follow the lane count.
- R6: An inactive lane outputs its old destination element unchanged.
- R7: dz_lane_o[i] is 1 only when lane i is active, the opcode is 4 and b is zero in that lane. exc_o is the OR of dz_lane_o.
- R8: While valid_o is high, elem_we_o equals the active mask. While valid_o is low, elem_we_o is zero. byte_we_o bits 2i and 2i+1 both equal elem_we_o[i].
- R9: With a count of 8, all eight lanes match the ordinary full-width result of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| op_i | input | 3 | Opcode |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| dst_old_i | input | 128 | Current destination contents |
| lane_cnt_i | input | 4 | Number of low lanes that take part |
| valid_o | output | 1 | Result strobe |
| dst_o | output | 128 | Merged destination vector |
| elem_we_o | output | 8 | Per-lane element write enable |
| byte_we_o | output | 16 | Per-byte write enable |
| dz_lane_o | output | 8 | Per-lane divide-by-zero flag |
| exc_o | output | 1 | Exception summary |

## Verification
The timing assertions assume that valid_i and lane_cnt_i hold a defined value at every clock edge after reset. The bench drives all inputs to zero before it releases reset. After that it changes inputs only on falling edges, so every sampled value is settled.

The per-lane keep check assumes the old destination presented with an instruction is the value that matters for that cycle. The bench drives a distinct old value in every lane so that a wrong merge shows up as a mismatch. Divisor vectors contain zeros only in the lanes a test deliberately targets, and those lanes fall on both sides of the active boundary.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MIN = 3'd2,
    OP_MAX = 3'd3,
    OP_DIV = 3'd4
  } simd_op_e;
endpackage

// File: rtl/simd_lane_mask.sv
module simd_lane_mask #(
  parameter int unsigned LANES = 8,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LANES-1:0] mask_o
);
  // thermometer: lane i active when count exceeds i; oversized counts saturate
  for (genvar i = 0; i < LANES; i++) begin : g_bit
    assign mask_o[i] = (cnt_i > CNT_W'(i));
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    old_i,
  output logic [W-1:0]    res_o,
  output logic            dz_o
);
  logic b_zero;
  assign b_zero = (b_i == '0);

  always_comb begin
    dz_o  = 1'b0;
    res_o = old_i;
    unique case (op_i)
      OP_ADD: res_o = a_i + b_i;
      OP_SUB: res_o = a_i - b_i;
      OP_MIN: res_o = (a_i < b_i) ? a_i : b_i;
      OP_MAX: res_o = (a_i > b_i) ? a_i : b_i;
      OP_DIV: begin
        dz_o  = b_zero;
        res_o = b_zero ? '1 : (a_i / b_i);
      end
      default: res_o = old_i;
    endcase
  end
endmodule

// File: rtl/simd_lane_exec.sv
module simd_lane_exec
  import simd_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  parameter int unsigned LW      = LANE_W,
  localparam int unsigned VW     = N_LANES * LW,
  localparam int unsigned BPL    = LW / 8,
  localparam int unsigned CNT_W  = $clog2(N_LANES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [OP_W-1:0]        op_i,
  input  logic [VW-1:0]          src_a_i,
  input  logic [VW-1:0]          src_b_i,
  input  logic [VW-1:0]          dst_old_i,
  input  logic [CNT_W-1:0]       lane_cnt_i,
  output logic                   valid_o,
  output logic [VW-1:0]          dst_o,
  output logic [N_LANES-1:0]     elem_we_o,
  output logic [N_LANES*BPL-1:0] byte_we_o,
  output logic [N_LANES-1:0]     dz_lane_o,
  output logic                   exc_o
);
  logic [N_LANES-1:0] mask;
  logic [N_LANES-1:0] lane_dz;
  logic [VW-1:0]      lane_res;
  logic [VW-1:0]      dst_nxt;

  simd_lane_mask #(.LANES(N_LANES)) u_mask (
    .cnt_i  (lane_cnt_i),
    .mask_o (mask)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    simd_lane_alu #(.W(LW)) u_alu (
      .op_i  (op_i),
      .a_i   (src_a_i[i*LW +: LW]),
      .b_i   (src_b_i[i*LW +: LW]),
      .old_i (dst_old_i[i*LW +: LW]),
      .res_o (lane_res[i*LW +: LW]),
      .dz_o  (lane_dz[i])
    );
    assign dst_nxt[i*LW +: LW] = mask[i] ? lane_res[i*LW +: LW] : dst_old_i[i*LW +: LW];
    assign byte_we_o[i*BPL +: BPL] = {BPL{elem_we_o[i]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      dst_o     <= '0;
      elem_we_o <= '0;
      dz_lane_o <= '0;
      exc_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o     <= dst_nxt;
        elem_we_o <= mask;
        dz_lane_o <= mask & lane_dz;
        exc_o     <= |(mask & lane_dz);
      end else begin
        elem_we_o <= '0;
        dz_lane_o <= '0;
        exc_o     <= 1'b0;
      end
    end
  end

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r3_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(elem_we_o) ==
      (($past(lane_cnt_i) > CNT_W'(N_LANES)) ? int'(N_LANES) : int'($past(lane_cnt_i))));

  a_r3_thermo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((elem_we_o + 1'b1) & elem_we_o) == '0);

  a_r7_dz_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dz_lane_o & ~elem_we_o) == '0);

  a_r7_exc_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> valid_o && $past(op_i) == OP_DIV);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (elem_we_o == '0) && !exc_o);

  for (genvar i = 0; i < N_LANES; i++) begin : g_keep_chk
    a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !elem_we_o[i]) |-> dst_o[i*LW +: LW] == $past(dst_old_i[i*LW +: LW]));
  end
endmodule

// File: tb/simd_lane_exec_bench.sv
module simd_lane_exec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int LW = 16;
  localparam int VW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [VW-1:0] a_i = '0, b_i = '0, old_i = '0;
  logic [3:0]    cnt_i = '0;
  logic          valid_o, exc_o;
  logic [VW-1:0] dst_o;
  logic [NL-1:0] elem_we_o, dz_lane_o;
  logic [2*NL-1:0] byte_we_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_lane_exec u_simd_lane_exec (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .src_a_i(a_i), .src_b_i(b_i), .dst_old_i(old_i), .lane_cnt_i(cnt_i),
    .valid_o(valid_o), .dst_o(dst_o), .elem_we_o(elem_we_o),
    .byte_we_o(byte_we_o), .dz_lane_o(dz_lane_o), .exc_o(exc_o)
  );

  task automatic chk(string tag, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] mk(int seed);
    logic [VW-1:0] v;
    for (int i = 0; i < NL; i++) v[i*LW +: LW] = 16'(seed * (i + 1) * 37 + i * 1013 + 5);
    return v;
  endfunction

  function automatic logic [LW-1:0] model(logic [2:0] op, logic [LW-1:0] a,
                                          logic [LW-1:0] b, logic [LW-1:0] o);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return (a < b) ? a : b;
      3'd3: return (a > b) ? a : b;
      3'd4: return (b == 0) ? 16'hFFFF : a / b;
      default: return o;
    endcase
  endfunction

  // drive at falling edge, sample just after the capturing rising edge
  task automatic issue(string tag, logic [2:0] op, logic [VW-1:0] a, logic [VW-1:0] b,
                       logic [VW-1:0] o, logic [3:0] cnt);
    logic [VW-1:0] e_dst;
    logic [NL-1:0] e_we, e_dz;
    logic [2*NL-1:0] e_bwe;
    int eff;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; old_i = o; cnt_i = cnt;
    eff = (cnt > 8) ? 8 : int'(cnt);
    for (int i = 0; i < NL; i++) begin
      e_we[i] = (i < eff);
      e_dst[i*LW +: LW] = e_we[i] ? model(op, a[i*LW +: LW], b[i*LW +: LW], o[i*LW +: LW])
                                  : o[i*LW +: LW];
      e_dz[i] = e_we[i] && op == 3'd4 && b[i*LW +: LW] == 0;
      e_bwe[2*i] = e_we[i];
      e_bwe[2*i+1] = e_we[i];
    end
    @(posedge clk); #1;
    chk("R2", "valid_o", VW'(valid_o), VW'(1'b1));
    chk(tag, "dst_o", dst_o, e_dst);
    chk("R8", "elem_we_o", VW'(elem_we_o), VW'(e_we));
    chk("R8", "byte_we_o", VW'(byte_we_o), VW'(e_bwe));
    chk("R7", "dz_lane_o", VW'(dz_lane_o), VW'(e_dz));
    chk("R7", "exc_o", VW'(exc_o), VW'(|e_dz));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    @(posedge clk); #1;
    chk("R2", "valid_o idle", VW'(valid_o), '0);
    chk("R8", "we idle", VW'({byte_we_o, elem_we_o}), '0);
    chk("R8", "exc idle", VW'(exc_o), '0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset outputs", VW'({valid_o, elem_we_o, byte_we_o, dz_lane_o, exc_o}), '0);
    chk("R1", "reset dst", dst_o, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_full_ops();
    for (int op = 0; op < 5; op++)
      issue("R9", 3'(op), mk(op + 11), mk(op + 3) | {NL{16'h0001}}, mk(99), 4'd8);
    idle();
  endtask

  task automatic t_wrap();
    issue("R4", 3'd0, {NL{16'hFFFF}}, {NL{16'h0002}}, mk(7), 4'd8);
    issue("R4", 3'd1, '0, {NL{16'h0001}}, mk(7), 4'd8);
    issue("R4", 3'd2, {NL{16'h8000}}, {NL{16'h7FFF}}, mk(7), 4'd8);
    issue("R4", 3'd3, {NL{16'h8000}}, {NL{16'h7FFF}}, mk(7), 4'd8);
    idle();
  endtask

  task automatic t_partial();
    issue("R6", 3'd0, mk(21), mk(22), mk(23), 4'd3);
    issue("R6", 3'd3, mk(24), mk(25), mk(26), 4'd6);
    idle();
  endtask

  task automatic t_div_zero();
    logic [VW-1:0] b;
    b = mk(31) | {NL{16'h0001}};
    b[1*LW +: LW] = '0;
    b[5*LW +: LW] = '0;
    issue("R7", 3'd4, mk(32), b, mk(33), 4'd4);
    issue("R7", 3'd4, mk(32), b, mk(33), 4'd1);
    issue("R4", 3'd4, mk(32), b, mk(33), 4'd8);
    idle();
  endtask

  task automatic t_counts();
    issue("R3", 3'd0, mk(41), mk(42), mk(43), 4'd0);
    issue("R3", 3'd1, mk(44), mk(45), mk(46), 4'd12);
    issue("R3", 3'd4, mk(47), '0, mk(48), 4'd0);
    idle();
  endtask

  task automatic t_reserved();
    issue("R5", 3'd6, mk(51), mk(52), mk(53), 4'd5);
    issue("R5", 3'd7, mk(54), mk(55), mk(56), 4'd8);
    idle();
  endtask

  task automatic t_back_to_back();
    issue("R2", 3'd0, mk(61), mk(62), mk(63), 4'd2);
    issue("R2", 3'd1, mk(64), mk(65), mk(66), 4'd7);
    issue("R2", 3'd2, mk(67), mk(68), mk(69), 4'd1);
    issue("R2", 3'd3, mk(70), mk(71), mk(72), 4'd8);
    idle();
  endtask

  initial begin
    t_reset();
    t_full_ops();
    t_wrap();
    t_partial();
    t_div_zero();
    t_counts();
    t_reserved();
    t_back_to_back();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule